// File: doc/BRIEF.md
# HDB3 Bipolar Line Encoder

This block turns a serial NRZ bit stream, one bit per clock qualified by a valid strobe, into a three-level line signal. The signal is carried on two wires: one asks the line driver for a positive pulse and the other for a negative pulse. Ones become pulses of alternating sign. Any run of four zeros is replaced by a pattern that contains a deliberate same-sign pulse, a violation, so a pulse appears on the line at least once in every four bit periods. This lets the far-end clock recovery stay locked.

The encoder holds the last four accepted bits in a look-ahead window, so it can rewrite the start of a zero run once the run is known to be complete. Each output symbol appears one clock after the input bit that comes four valid bits later. Cycles with the strobe low stall the window and produce no output symbol. The analog driver and any half-width pulse timing sit outside this block.

Top module: `hdb3_encoder`

## Requirements
- R1: After reset, out_valid, pos and neg are low, and the first pulse sent is positive (the last pulse is taken as negative and the pulse count as even).
- R2: A one bit is sent as a pulse whose sign is opposite to the pulse sent just before it (pos=1 means positive, neg=1 means negative).
- R3: The symbol for the k-th accepted bit appears, with out_valid high, in the clock after the (k+4)-th bit is accepted. out_valid is low in every other cycle, and pos and neg are low whenever out_valid is low.
- R4: Four zeros, when an odd number of pulses has been sent since the last violation, become zero, zero, zero, then a pulse of the same sign as the preceding pulse.
- R5: Four zeros, when that count is even, become a pulse of opposite sign to the preceding pulse, zero, zero, then a second pulse of that same sign.
- R6: The pulse count includes ordinary marks and the filler pulse of R5, and it returns to even after every violation. A zero run is only replaced once its fourth zero has arrived, and runs are counted from the first zero after a pulse or after a replaced run.
- R7: pos and neg are never high in the same cycle.
- R8: Among the valid output symbols there are never more than three zero symbols in a row.
- R9: A synchronous reset in the middle of a stream discards the buffered bits and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | in_bit carries a data bit this cycle |
| in_bit | input | 1 | Serial NRZ data bit |
| out_valid | output | 1 | pos/neg carry a line symbol this cycle |
| pos | output | 1 | Send a positive pulse |
| neg | output | 1 | Send a negative pulse |

## Verification
Two events can land in the same accepted bit. In one, a completed zero run writes its filler pulse back into the oldest window slot while that slot's previous occupant is shifting out to the line. In the other, the sign and count state must absorb both the filler and the violation in one step. A stream of zeros straight after reset drives the filler write while the window is still filling. Back-to-back zero runs, runs that follow odd and even pulse counts, and long zero-biased random streams with idle gaps drive the two events together. Each case is judged symbol by symbol against a scoreboard. The scoreboard is filled by a scan of the whole bit sequence that looks ahead for complete zero runs.

// File: rtl/hdb3_pkg.sv
package hdb3_pkg;

    // Length of a zero run that triggers substitution; also the look-ahead depth.
    localparam int RUN_LEN = 4;
    localparam int RUN_W   = $clog2(RUN_LEN);

    typedef enum logic {
        POL_NEG = 1'b0,
        POL_POS = 1'b1
    } pol_t;

    typedef struct packed {
        logic p;
        logic n;
    } sym_t;

    localparam sym_t SYM_ZERO = '{p: 1'b0, n: 1'b0};

    function automatic sym_t pulse_of(pol_t pol);
        sym_t s;
        s.p = (pol == POL_POS);
        s.n = (pol == POL_NEG);
        return s;
    endfunction

    function automatic pol_t flip(pol_t pol);
        return (pol == POL_POS) ? POL_NEG : POL_POS;
    endfunction

endpackage

// File: rtl/hdb3_rules.sv
module hdb3_rules
    import hdb3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic din,
    output sym_t new_sym,
    output logic fill_b,
    output sym_t b_sym
);

    pol_t             last_pol, last_pol_n;
    logic             odd_cnt, odd_cnt_n;
    logic [RUN_W-1:0] zrun, zrun_n;
    logic             run_done;
    pol_t             b_pol;

    assign run_done = !din && (zrun == RUN_W'(RUN_LEN - 1));
    assign b_pol    = flip(last_pol);

    always_comb begin
        new_sym    = SYM_ZERO;
        fill_b     = 1'b0;
        b_sym      = pulse_of(b_pol);
        last_pol_n = last_pol;
        odd_cnt_n  = odd_cnt;
        zrun_n     = zrun;
        if (din) begin
            new_sym    = pulse_of(b_pol);
            last_pol_n = b_pol;
            odd_cnt_n  = !odd_cnt;
            zrun_n     = '0;
        end else if (run_done) begin
            zrun_n    = '0;
            odd_cnt_n = 1'b0;
            if (odd_cnt) begin
                new_sym = pulse_of(last_pol);
            end else begin
                fill_b     = 1'b1;
                new_sym    = pulse_of(b_pol);
                last_pol_n = b_pol;
            end
        end else begin
            zrun_n = zrun + RUN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_pol <= POL_NEG;
            odd_cnt  <= 1'b0;
            zrun     <= '0;
        end else if (take) begin
            last_pol <= last_pol_n;
            odd_cnt  <= odd_cnt_n;
            zrun     <= zrun_n;
        end
    end

endmodule

// File: rtl/hdb3_window.sv
module hdb3_window
    import hdb3_pkg::*;
#(
    parameter int DEPTH = RUN_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  sym_t din,
    input  logic fill_b,
    input  sym_t b_sym,
    output sym_t dout,
    output logic full
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    sym_t             stage [DEPTH];
    logic [CNT_W-1:0] fill_cnt;

    assign dout = stage[DEPTH-1];
    assign full = (fill_cnt == CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            stage[0] <= SYM_ZERO;
        end else if (take) begin
            stage[0] <= din;
        end
    end

    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        if (k == DEPTH - 1) begin : g_oldest
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[k] <= SYM_ZERO;
                end else if (take) begin
                    stage[k] <= fill_b ? b_sym : stage[k-1];
                end
            end
        end else begin : g_mid
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[k] <= SYM_ZERO;
                end else if (take) begin
                    stage[k] <= stage[k-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt <= '0;
        end else if (take && !full) begin
            fill_cnt <= fill_cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/hdb3_encoder.sv
module hdb3_encoder
    import hdb3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_bit,
    output logic out_valid,
    output logic pos,
    output logic neg
);

    sym_t new_sym, b_sym, old_sym;
    logic fill_b, win_full;

    hdb3_rules u_rules (
        .clk     (clk),
        .rst     (rst),
        .take    (in_valid),
        .din     (in_bit),
        .new_sym (new_sym),
        .fill_b  (fill_b),
        .b_sym   (b_sym)
    );

    hdb3_window #(.DEPTH(RUN_LEN)) u_window (
        .clk    (clk),
        .rst    (rst),
        .take   (in_valid),
        .din    (new_sym),
        .fill_b (fill_b),
        .b_sym  (b_sym),
        .dout   (old_sym),
        .full   (win_full)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            pos       <= 1'b0;
            neg       <= 1'b0;
        end else if (in_valid && win_full) begin
            out_valid <= 1'b1;
            pos       <= old_sym.p;
            neg       <= old_sym.n;
        end else begin
            out_valid <= 1'b0;
            pos       <= 1'b0;
            neg       <= 1'b0;
        end
    end

endmodule

// File: rtl/hdb3_encoder_chk.sv
module hdb3_encoder_chk (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic out_valid,
    input logic pos,
    input logic neg
);

    logic [2:0] zeros_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            zeros_seen <= '0;
        end else if (out_valid) begin
            if (pos || neg) begin
                zeros_seen <= '0;
            end else if (zeros_seen != 3'd7) begin
                zeros_seen <= zeros_seen + 3'd1;
            end
        end
    end

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(pos && neg));                                             // R7

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!pos && !neg));                             // R3

    AST_OUTPUT_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));                             // R3

    AST_ZERO_RUN_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !pos && !neg) |-> (zeros_seen < 3'd3));       // R8

endmodule

bind hdb3_encoder hdb3_encoder_chk u_chk (.*);

// File: tb/hdb3_encoder_bench.sv
module hdb3_encoder_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic out_valid, pos, neg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];
    int         stim[$];
    int         zrun_obs = 0;

    always #2.5 clk = ~clk;

    hdb3_encoder u_hdb3_encoder (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_bit    (in_bit),
        .out_valid (out_valid),
        .pos       (pos),
        .neg       (neg)
    );

    function automatic logic [1:0] sym_of(int pol);
        return (pol > 0) ? 2'b10 : 2'b01;
    endfunction

    // Expected symbols by scanning the whole sequence for complete four-zero runs.
    task automatic push_expect(string tag);
        int pol = -1;
        int odd = 0;
        int i = 0;
        int n = stim.size();
        logic [1:0] e[$];
        while (i < n) begin
            if (i + 3 < n && stim[i] == 0 && stim[i+1] == 0 &&
                stim[i+2] == 0 && stim[i+3] == 0) begin
                if (odd == 1) begin
                    e.push_back(2'b00); e.push_back(2'b00); e.push_back(2'b00);
                    e.push_back(sym_of(pol));
                end else begin
                    pol = -pol;
                    e.push_back(sym_of(pol)); e.push_back(2'b00); e.push_back(2'b00);
                    e.push_back(sym_of(pol));
                end
                odd = 0;
                i += 4;
            end else if (stim[i] != 0) begin
                pol = -pol;
                odd = 1 - odd;
                e.push_back(sym_of(pol));
                i++;
            end else begin
                e.push_back(2'b00);
                i++;
            end
        end
        for (int k = 0; k + 4 < n; k++) begin
            exp_q.push_back(e[k]);
            tag_q.push_back(tag);
        end
    endtask

    task automatic drive_stim(int gaps);
        for (int k = 0; k < stim.size(); k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_bit   = (stim[k] != 0);
            if (gaps != 0 && ($urandom % 3) == 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_bit   = 1'b1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_bit   = 1'b0;
    endtask

    task automatic run_stim(string tag, int gaps);
        push_expect(tag);
        drive_stim(gaps);
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s/R3: %0d outputs missing, expected 0 left", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || pos !== 1'b0 || neg !== 1'b0) begin
            errors++;
            $display("FAIL R1: in reset got v=%b p=%b n=%b expected 000", out_valid, pos, neg);
        end
        exp_q.delete();
        tag_q.delete();
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || pos !== 1'b0 || neg !== 1'b0) begin
            errors++;
            $display("FAIL R1: after reset got v=%b p=%b n=%b expected 000", out_valid, pos, neg);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (pos && neg) begin
                checks++;
                errors++;
                $display("FAIL R7: pos=1 neg=1 expected not both");
            end
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R3: unexpected output %b%b expected none", pos, neg);
                end else begin
                    logic [1:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if ({pos, neg} !== e) begin
                        errors++;
                        $display("FAIL %s: symbol {pos,neg}=%b%b expected %b", t, pos, neg, e);
                    end
                end
                if (!pos && !neg) zrun_obs++;
                else zrun_obs = 0;
                if (zrun_obs > 3) begin
                    checks++;
                    errors++;
                    $display("FAIL R8: %0d zero symbols in a row expected at most 3", zrun_obs);
                end
            end else if (pos || neg) begin
                checks++;
                errors++;
                $display("FAIL R3: pulse %b%b while out_valid low expected 00", pos, neg);
            end
        end else begin
            zrun_obs = 0;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R1 R2: all ones alternate, starting positive
        stim = '{1,1,1,1,1,1,1,1,1,1};
        run_stim("R2", 0);

        // R4: one mark (odd count) then four zeros -> 000V
        do_reset();
        stim = '{1,0,0,0,0,1,1,1,1,1};
        run_stim("R4", 0);

        // R5: two marks (even count) then four zeros -> B00V
        do_reset();
        stim = '{1,1,0,0,0,0,1,1,1,1,1};
        run_stim("R5", 0);

        // R6: zeros from reset; back-to-back runs with B written while filling
        do_reset();
        stim = '{0,0,0,0,0,0,0,0,0,0,0,0,1,0,0,0,0,0,1,1,1,1};
        run_stim("R6", 0);

        // R6: three zeros then a one is not replaced
        do_reset();
        stim = '{1,0,0,0,1,0,0,0,0,1,0,1,1,1,1};
        run_stim("R6_short", 0);

        // R3: idle gaps between valid bits
        do_reset();
        stim = '{1,0,0,0,0,1,0,1,0,0,0,0,0,0,0,0,1,1,1,1};
        run_stim("R3", 1);

        // R9: reset in mid-stream discards buffered bits and state
        do_reset();
        stim = '{1,0,0};
        drive_stim(0);
        do_reset();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: queue %0d expected 0", exp_q.size());
        end
        stim = '{1,0,0,0,0,0,0,0,0,1,1,1,1};
        run_stim("R9", 0);

        // R8: zero-biased random streams with gaps
        for (int r = 0; r < 4; r++) begin
            do_reset();
            stim.delete();
            for (int k = 0; k < 300; k++) stim.push_back((($urandom % 4) == 0) ? 1 : 0);
            run_stim("R8", r % 2);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule